// File: doc/BRIEF.md
# Boolean Bit-Operation Unit

This block is the single-bit processing engine of an 8-bit microcontroller data path. It takes an 8-bit bit address and splits it into a byte address and a bit position within that byte. The lower half of the bit-address space covers a 16-byte internal RAM window starting at byte 20H. The upper half covers the special function register bytes whose addresses are multiples of eight. A parameter mask says which of those 16 register slots exist.

Each operation is a read-modify-write of one whole byte over a byte-wide memory port. It takes exactly two cycles. In the first cycle the byte is read and the new value is computed. In the second cycle the merged byte is written back and `done` pulses. A carry flag serves as a one-bit accumulator. It can be cleared, set, complemented, loaded from a bit, stored into a bit, or combined with a bit by AND or OR. A test operation reports through `branch_taken` whether the addressed bit is 1.

Top module: `bitop_unit`

## Requirements
- R1: A bit address below 80H selects byte 20H + addr[6:3] and bit addr[2:0]. For example, 00H is bit 0 of byte 20H and 7FH is bit 7 of byte 2FH.
- R2: A bit address of 80H or above selects byte {addr[7:3],000} and bit addr[2:0]. For example, 83H is bit 3 of byte 80H.
- R3: Op 0 clears, op 1 sets and op 2 inverts the addressed bit. The byte is written back with the other seven bits unchanged.
- R4: Op 3 loads carry from the addressed bit and leaves memory untouched. Op 4 writes the current carry into the addressed bit.
- R5: Op 5 sets carry to carry AND bit. Op 6 sets carry to carry OR bit. Neither op writes memory.
- R6: Op 7 makes `branch_taken` equal to the addressed bit. Every other op makes it 0. The value appears in the `done` cycle and holds until the next op.
- R7: Op 8 clears carry, op 9 sets carry and op 10 inverts carry, with no memory write. Ops 11 to 15 change neither carry nor memory. Carry changes only on entry to a `done` cycle.
- R8: A register slot in the upper range whose mask bit is 0 reads as 0. The unit never reads or writes that slot: no `mem_rd` and no `mem_we`.
- R9: After a `start` is accepted, `mem_rd` and the byte address are driven in the next cycle. In the cycle after that, `done` is high for exactly one cycle, and any write is issued in that same cycle. `start` is ignored while an op is in progress.
- R10: After reset, carry, `branch_taken`, `done`, `mem_rd` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 4 | Operation code (see R3 to R7) |
| bit_addr | input | 8 | Flat bit address |
| mem_addr | output | 8 | Byte address to the RAM/register port |
| mem_rd | output | 1 | Byte read request (read data valid in the same cycle) |
| mem_rdata | input | 8 | Byte read data |
| mem_we | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Merged byte to write |
| carry | output | 1 | One-bit accumulator |
| branch_taken | output | 1 | Result of the bit test |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the ends of both address halves: 00H, 7FH, 80H, and register slots with a 0 in the mask. A wrong mapping changes a neighbouring byte and leaves the expected one unchanged. An absent slot is preloaded with ones, so a design that reads it returns 1 to carry, and one that writes it corrupts the preload. Inverts and carry stores run against random bytes, so a merge that disturbs other bits shows up as a byte mismatch. A `start` held high through a running op would, if accepted, cause a second `done` or an extra carry change.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        OP_CLRB = 4'd0,
        OP_SETB = 4'd1,
        OP_CPLB = 4'd2,
        OP_LDC  = 4'd3,
        OP_STC  = 4'd4,
        OP_ANDC = 4'd5,
        OP_ORC  = 4'd6,
        OP_JSET = 4'd7,
        OP_CLRC = 4'd8,
        OP_SETC = 4'd9,
        OP_CPLC = 4'd10
    } bop_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        bop_e       op;
        logic [7:0] baddr;
        logic [2:0] bidx;
        logic       hit;
        logic [7:0] wbyte;
        logic       wr;
        logic       carry;
        logic       branch;
    } bstate_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode #(
    parameter logic [7:0]  RAM_BASE = 8'h20,
    parameter logic [15:0] SFR_MAP  = 16'h7BFF
) (
    input  logic [7:0] bit_addr,
    output logic [7:0] byte_addr,
    output logic [2:0] bit_idx,
    output logic       hit
);
    localparam int SLOT_W = 4;

    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot    = bit_addr[6:3];
        bit_idx = bit_addr[2:0];
        if (!bit_addr[7]) begin
            byte_addr = RAM_BASE + {4'b0000, slot};
            hit       = 1'b1;
        end else begin
            byte_addr = {bit_addr[7:3], 3'b000};
            hit       = SFR_MAP[slot];
        end
    end

endmodule

// File: rtl/bitop_merge.sv
module bitop_merge
    import bitop_pkg::*;
(
    input  bop_e       op,
    input  logic [7:0] rbyte,
    input  logic [2:0] idx,
    input  logic       carry_in,
    output logic [7:0] wbyte,
    output logic       wr,
    output logic       carry_out,
    output logic       branch
);
    logic bitv;

    always_comb begin
        bitv      = rbyte[idx];
        wbyte     = rbyte;
        wr        = 1'b0;
        carry_out = carry_in;
        branch    = 1'b0;
        case (op)
            OP_CLRB: begin wbyte[idx] = 1'b0;     wr = 1'b1; end
            OP_SETB: begin wbyte[idx] = 1'b1;     wr = 1'b1; end
            OP_CPLB: begin wbyte[idx] = ~bitv;    wr = 1'b1; end
            OP_STC:  begin wbyte[idx] = carry_in; wr = 1'b1; end
            OP_LDC:  carry_out = bitv;
            OP_ANDC: carry_out = carry_in & bitv;
            OP_ORC:  carry_out = carry_in | bitv;
            OP_JSET: branch    = bitv;
            OP_CLRC: carry_out = 1'b0;
            OP_SETC: carry_out = 1'b1;
            OP_CPLC: carry_out = ~carry_in;
            default: ;
        endcase
    end

    // R3: the merged byte differs from the read byte in at most one bit
    always_comb begin
        p_one_bit_r3: assert ($countones(wbyte ^ rbyte) <= 1);
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter logic [7:0]  RAM_BASE = 8'h20,
    parameter logic [15:0] SFR_MAP  = 16'h7BFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] op,
    input  logic [7:0] bit_addr,
    output logic [7:0] mem_addr,
    output logic       mem_rd,
    input  logic [7:0] mem_rdata,
    output logic       mem_we,
    output logic [7:0] mem_wdata,
    output logic       carry,
    output logic       branch_taken,
    output logic       done
);
    bstate_t    st_q, st_d;
    logic [7:0] dec_byte;
    logic [2:0] dec_idx;
    logic       dec_hit;
    logic [7:0] rbyte;
    logic [7:0] m_wbyte;
    logic       m_wr, m_carry, m_branch;

    bitop_decode #(.RAM_BASE(RAM_BASE), .SFR_MAP(SFR_MAP)) u_dec (
        .bit_addr (bit_addr),
        .byte_addr(dec_byte),
        .bit_idx  (dec_idx),
        .hit      (dec_hit)
    );

    assign rbyte = st_q.hit ? mem_rdata : 8'h00;

    bitop_merge u_merge (
        .op       (st_q.op),
        .rbyte    (rbyte),
        .idx      (st_q.bidx),
        .carry_in (st_q.carry),
        .wbyte    (m_wbyte),
        .wr       (m_wr),
        .carry_out(m_carry),
        .branch   (m_branch)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph    = PH_RD;
                    st_d.op    = bop_e'(op);
                    st_d.baddr = dec_byte;
                    st_d.bidx  = dec_idx;
                    st_d.hit   = dec_hit;
                    st_d.wr    = 1'b0;
                end
            end
            PH_RD: begin
                st_d.ph     = PH_WR;
                st_d.wbyte  = m_wbyte;
                st_d.wr     = m_wr & st_q.hit;
                st_d.carry  = m_carry;
                st_d.branch = m_branch;
            end
            default: begin
                st_d.ph = PH_IDLE;
                st_d.wr = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr     = (st_q.ph != PH_IDLE) ? st_q.baddr : 8'h00;
    assign mem_rd       = (st_q.ph == PH_RD) && st_q.hit;
    assign mem_we       = (st_q.ph == PH_WR) && st_q.wr;
    assign mem_wdata    = st_q.wbyte;
    assign done         = (st_q.ph == PH_WR);
    assign carry        = st_q.carry;
    assign branch_taken = st_q.branch;

    // R9: done is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: writes only happen in the done cycle
    p_we_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> done);

    // R3: write-back goes to the byte that was read
    p_wr_same_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == $past(mem_addr));

    // R8: an absent register slot is never accessed
    p_absent_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_we) |-> (!mem_addr[7] || SFR_MAP[mem_addr[6:3]]));

    // R7: carry only changes on entry to a done cycle
    p_carry_moves_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry) |-> done);

    // R7: carry-only and test ops never write memory
    p_write_ops_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st_q.op inside {OP_CLRB, OP_SETB, OP_CPLB, OP_STC}));

endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] MAP        = 16'h7BFF;

    typedef struct packed {
        logic [7:0] nb;
        logic       c;
        logic       br;
        logic       wr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] bit_addr = 8'd0;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;
    logic       mem_rd, mem_we, carry, branch_taken, done;

    logic [7:0] mem [256];
    int         wcount = 0;
    int         checks = 0;
    int         fails = 0;
    logic       mcarry = 1'b0;
    bit         finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit #(.RAM_BASE(8'h20), .SFR_MAP(MAP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .carry(carry),
        .branch_taken(branch_taken), .done(done)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wcount <= wcount + 1;
        end
    end

    function automatic logic [7:0] byte_of(input logic [7:0] a);
        return a[7] ? {a[7:3], 3'b000} : 8'h20 + {4'b0000, a[6:3]};
    endfunction

    function automatic logic present_of(input logic [7:0] a);
        return !a[7] || MAP[a[6:3]];
    endfunction

    function automatic exp_t model(input logic [3:0] o, input logic [7:0] old,
                                   input logic [2:0] idx, input logic pres, input logic c);
        exp_t e;
        logic b;
        b    = pres ? old[idx] : 1'b0;
        e.nb = old; e.c = c; e.br = 1'b0; e.wr = 1'b0;
        case (o)
            4'd0: begin e.nb[idx] = 1'b0; e.wr = pres; end
            4'd1: begin e.nb[idx] = 1'b1; e.wr = pres; end
            4'd2: begin e.nb[idx] = ~b;   e.wr = pres; end
            4'd3: e.c = b;
            4'd4: begin e.nb[idx] = c;    e.wr = pres; end
            4'd5: e.c = c & b;
            4'd6: e.c = c | b;
            4'd7: e.br = b;
            4'd8: e.c = 1'b0;
            4'd9: e.c = 1'b1;
            4'd10: e.c = ~c;
            default: ;
        endcase
        if (!pres) e.nb = old;
        return e;
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        if (o <= 4'd2) return "R3";
        if (o <= 4'd4) return "R4";
        if (o <= 4'd6) return "R5";
        if (o == 4'd7) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] o, input logic [7:0] a);
        logic [7:0] by;
        logic       pres;
        exp_t       e;
        int         wc0;
        string      maptag;
        by     = byte_of(a);
        pres   = present_of(a);
        maptag = a[7] ? "R2" : "R1";
        e      = model(o, mem[by], a[2:0], pres, mcarry);
        @(negedge clk);
        start = 1'b1; op = o; bit_addr = a;
        wc0   = wcount;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R9", "done in read cycle", done, 0);
        check(mem_rd == pres, pres ? "R9" : "R8", "mem_rd", mem_rd, pres);
        if (pres) check(mem_addr == by, maptag, "byte address", mem_addr, by);
        @(negedge clk);
        check(done == 1'b1, "R9", "done in second cycle", done, 1);
        check(carry == e.c, tag_of(o), "carry", carry, e.c);
        check(branch_taken == e.br, "R6", "branch_taken", branch_taken, e.br);
        check(mem_we == e.wr, pres ? tag_of(o) : "R8", "mem_we", mem_we, e.wr);
        @(negedge clk);
        check(done == 1'b0, "R9", "done after pulse", done, 0);
        check(mem[by] == e.nb, pres ? tag_of(o) : "R8", "byte value", mem[by], e.nb);
        check(wcount - wc0 == int'(e.wr), pres ? tag_of(o) : "R8", "write count",
              wcount - wc0, int'(e.wr));
        mcarry = e.c;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired: actual 1 expected 0");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        mem[8'hD0] = 8'hFF;
        mem[8'hF8] = 8'hFF;
        mem[8'h20] = 8'h5A;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(carry == 1'b0, "R10", "carry at reset", carry, 0);
        check(branch_taken == 1'b0, "R10", "branch at reset", branch_taken, 0);
        check(done == 1'b0, "R10", "done at reset", done, 0);
        check(mem_rd == 1'b0 && mem_we == 1'b0, "R10", "port strobes at reset",
              {mem_rd, mem_we}, 0);
        rst_n = 1'b1;

        // R1 edges of the RAM window
        do_op(4'd1, 8'h00);
        do_op(4'd0, 8'h07);
        do_op(4'd2, 8'h7F);
        do_op(4'd1, 8'h78);
        // R2 register slots
        do_op(4'd1, 8'h83);
        do_op(4'd2, 8'h80);
        do_op(4'd0, 8'hE7);
        // R7 carry ops
        do_op(4'd9, 8'h10);
        do_op(4'd10, 8'h10);
        do_op(4'd10, 8'h10);
        do_op(4'd8, 8'h10);
        do_op(4'd12, 8'h22);
        // R4 store and load carry
        do_op(4'd9, 8'h00);
        do_op(4'd4, 8'h31);
        do_op(4'd8, 8'h00);
        do_op(4'd3, 8'h31);
        // R5 and R6
        do_op(4'd5, 8'h01);
        do_op(4'd6, 8'h02);
        do_op(4'd7, 8'h00);
        do_op(4'd7, 8'h07);
        // R8 absent slots preloaded with ones
        do_op(4'd3, 8'hD5);
        do_op(4'd1, 8'hD2);
        do_op(4'd0, 8'hFF);
        do_op(4'd7, 8'hFB);
        do_op(4'd4, 8'hD0);

        // R9 start held high during a running op is ignored
        do_op(4'd9, 8'h00);
        @(negedge clk);
        start = 1'b1; op = 4'd8; bit_addr = 8'h00;
        @(negedge clk);
        op = 4'd10;
        @(negedge clk);
        check(done == 1'b1, "R9", "done of accepted op", done, 1);
        check(carry == 1'b0, "R9", "carry of accepted op", carry, 0);
        @(negedge clk);
        start = 1'b0;
        check(carry == 1'b0, "R9", "carry after busy start", carry, 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "no extra done", done, 0);
        @(negedge clk);
        check(done == 1'b0 && carry == 1'b0, "R9", "still idle", {done, carry}, 0);
        mcarry = 1'b0;

        // mixed random ops
        for (int k = 0; k < 400; k++) begin
            do_op(4'($urandom_range(0, 15)), 8'($urandom));
        end
        report();
    end

endmodule